// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Engine

This block is a bus-master DMA engine. It moves data between system memory and a device-side word stream, following a list of memory segments that software leaves in a table in memory. Each table entry takes two 32-bit words. The first word is the segment byte address, and its bit 0 marks the final entry. The second word is the segment byte length. Software writes the table base, picks a direction and sets the start bit. The engine then reads the entries in order and moves each segment as 32-bit beats, until it has finished the entry that carries the final mark.

The engine sets an active flag while it runs. When it completes, it raises a sticky done flag and pulses one completion output. A stop request or a memory error response ends a run early. A hold bit in the control register keeps the whole engine in its reset state. Memory is reached through a single request/acknowledge port. Each request stays asserted until it is acknowledged.

Top module: `sgdma_engine`

## Requirements
- R1: After reset, all three registers read 0 and the block asserts no memory request and no completion pulse. Register selects: 0 = control, 1 = status, 2 = table base.
- R2: Entry i sits at base + 8*i. Its address word is read first and its length word (base + 8*i + 4) second. Entries are processed strictly in table order.
- R3: Bit 0 of an entry's address word marks the last entry. The segment start address is that word with bit 0 forced to 0.
- R4: Only bits 28:0 of the length word form the byte count. Bits 31:29 have no effect.
- R5: Control bit 2 picks the direction. With 1, data taken from the device input stream is written to memory. With 0, data read from memory is sent on the device output stream. The bit can be changed only while the engine is idle.
- R6: Writing control bit 0 = 1 while idle and not held starts a run at the table base. Status bit 0, and control bit 0 on readback, are 1 while a run is in progress.
- R7: Writing control bit 1 = 1 during a run ends the run. Active clears, no further memory requests are issued, and the done flag stays clear.
- R8: When the last segment completes, active clears in the same cycle that status bit 6 (done) sets and the completion output pulses high for exactly one cycle. Writing 1 to status bit 6 clears the flag.
- R9: An entry with a zero byte count produces no data beats. If it is also the last entry, the run completes.
- R10: While control bit 7 is 1, start writes are ignored, any run in progress ends, and status bits 2, 4 and 6 are held at 0.
- R11: A memory response that has the error input set sets status bit 2 and ends the run without setting done. Writing 1 to bit 2 clears the flag.
- R12: A high level on the device interrupt input sets sticky status bit 4. Writing 1 to bit 4 clears it.
- R13: A segment of L bytes moves ceil(L/4) beats of 32 bits at consecutive word addresses. A memory request stays asserted, with a stable address, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 status, 2 base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error flag qualifying mem_ack |
| mem_rdata | input | 32 | Memory read data qualifying mem_ack |
| dev_in_valid | input | 1 | Device input word valid |
| dev_in_data | input | 32 | Device input word |
| dev_in_ready | output | 1 | Engine accepts device input word |
| dev_out_valid | output | 1 | Device output word valid |
| dev_out_data | output | 32 | Device output word |
| dev_out_ready | input | 1 | Device accepts output word |
| dev_irq | input | 1 | Device interrupt level |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds tables with random segment counts and lengths, including lengths that are not multiples of four. Zero-length entries are mixed in, in the middle and at the end of a table. A design that miscounted beats, or issued a beat for an empty entry, would corrupt the expected memory image or the device log, and would issue the wrong total number of memory requests. Garbage is placed in length bits 31:29 and the final mark in address bit 0, so a design that kept either bit would move data to the wrong place or run too long. Stop, hold and error responses are injected in the middle of a run, and the bench watches that requests cease, that done stays clear and that the completion pulse does not appear.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FADDR,
    ST_FLEN,
    ST_GET,
    ST_PUT
  } seq_state_e;

  localparam int CTRL_START  = 0;
  localparam int CTRL_STOP   = 1;
  localparam int CTRL_DIR    = 2;
  localparam int CTRL_HOLD   = 7;

  localparam int STAT_ACTIVE = 0;
  localparam int STAT_ERR    = 2;
  localparam int STAT_DEVINT = 4;
  localparam int STAT_DONE   = 6;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          done_evt,
  input  logic          err_evt,
  input  logic          dev_irq,
  output logic          go,
  output logic          stop_req,
  output logic          dir,
  output logic          hold,
  output logic [DW-1:0] base,
  output logic          done_pulse
);
  logic          hold_q, hold_n;
  logic          dir_q, dir_n;
  logic [DW-1:0] base_q, base_n;
  logic          err_q, err_n;
  logic          dint_q, dint_n;
  logic          done_q, done_n;
  logic          pulse_q, pulse_n;
  logic          wr_ctrl, wr_stat, wr_base;
  logic [DW-1:0] clr;

  always_comb begin
    wr_ctrl  = reg_we && (reg_sel == SEL_CTRL);
    wr_stat  = reg_we && (reg_sel == SEL_STAT);
    wr_base  = reg_we && (reg_sel == SEL_BASE);
    clr      = wr_stat ? reg_wdata : '0;
    hold_n   = wr_ctrl ? reg_wdata[CTRL_HOLD] : hold_q;
    dir_n    = (wr_ctrl && !busy) ? reg_wdata[CTRL_DIR] : dir_q;
    base_n   = (wr_base && !busy) ? reg_wdata : base_q;
    go       = wr_ctrl && reg_wdata[CTRL_START] && !reg_wdata[CTRL_HOLD]
               && !hold_q && !busy;
    stop_req = wr_ctrl && reg_wdata[CTRL_STOP] && busy;
    err_n    = !hold_q && (err_evt  || (err_q  && !clr[STAT_ERR]));
    dint_n   = !hold_q && (dev_irq  || (dint_q && !clr[STAT_DEVINT]));
    done_n   = !hold_q && (done_evt || (done_q && !clr[STAT_DONE]));
    pulse_n  = done_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      dir_q   <= 1'b0;
      base_q  <= '0;
      err_q   <= 1'b0;
      dint_q  <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      hold_q  <= hold_n;
      dir_q   <= dir_n;
      base_q  <= base_n;
      err_q   <= err_n;
      dint_q  <= dint_n;
      done_q  <= done_n;
      pulse_q <= pulse_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_START] = busy;
        reg_rdata[CTRL_DIR]   = dir_q;
        reg_rdata[CTRL_HOLD]  = hold_q;
      end
      SEL_STAT: begin
        reg_rdata[STAT_ACTIVE] = busy;
        reg_rdata[STAT_ERR]    = err_q;
        reg_rdata[STAT_DEVINT] = dint_q;
        reg_rdata[STAT_DONE]   = done_q;
      end
      SEL_BASE: reg_rdata = base_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign dir        = dir_q;
  assign hold       = hold_q;
  assign base       = base_q;
  assign done_pulse = pulse_q;

  // R8: the done flag survives until software clears it or hold is applied
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !hold_q && !(wr_stat && reg_wdata[STAT_DONE])) |=> done_q);

  // R12: a device interrupt level is always captured
  assert_devint_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq && !hold_q) |=> (reg_sel != SEL_STAT) || reg_rdata[STAT_DEVINT]);
endmodule

// File: rtl/sgdma_seg.sv
module sgdma_seg #(
  parameter int AW         = 32,
  parameter int LEN_W      = 29,
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_addr,
  input  logic [AW-1:1]    addr_in,
  input  logic             load_len,
  input  logic [LEN_W-1:0] len_in,
  input  logic             step,
  output logic [AW-1:0]    seg_addr,
  output logic             len_zero,
  output logic             last_beat
);
  localparam logic [LEN_W-1:0] BEAT  = LEN_W'(BEAT_BYTES);
  localparam logic [AW-1:0]    ASTEP = AW'(BEAT_BYTES);

  logic [AW-1:0]    addr_q, addr_n;
  logic [LEN_W-1:0] remain_q, remain_n;

  always_comb begin
    addr_n   = addr_q;
    remain_n = remain_q;
    if (load_addr)      addr_n = {addr_in, 1'b0};
    else if (step)      addr_n = addr_q + ASTEP;
    if (load_len)       remain_n = len_in;
    else if (step)      remain_n = (remain_q > BEAT) ? remain_q - BEAT : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
    end else begin
      addr_q   <= addr_n;
      remain_q <= remain_n;
    end
  end

  assign seg_addr  = addr_q;
  assign len_zero  = (remain_q == '0);
  assign last_beat = (remain_q <= BEAT);

  // R9: a beat is never taken from a segment with nothing left
  assert_step_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !len_zero);
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEN_W      = 29,
  parameter int BEAT_BYTES = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          stop_req,
  input  logic          hold,
  input  logic          dir,
  input  logic [AW-1:0] base,
  output logic          busy,
  output logic          done_evt,
  output logic          err_evt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready
);
  localparam logic [AW-1:0] WORD_OFS  = AW'(4);
  localparam logic [AW-1:0] ENTRY_OFS = AW'(8);

  seq_state_e    state_q, state_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          last_q, last_n;
  logic [DW-1:0] buf_q, buf_n;
  logic          ld_a, ld_l, step;
  logic [AW-1:0] seg_addr;
  logic          len_zero, last_beat;
  logic          advance;

  sgdma_seg #(.AW(AW), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_addr (ld_a),
    .addr_in   (mem_rdata[AW-1:1]),
    .load_len  (ld_l),
    .len_in    (mem_rdata[LEN_W-1:0]),
    .step      (step),
    .seg_addr  (seg_addr),
    .len_zero  (len_zero),
    .last_beat (last_beat)
  );

  always_comb begin
    state_n       = state_q;
    ptr_n         = ptr_q;
    last_n        = last_q;
    buf_n         = buf_q;
    ld_a          = 1'b0;
    ld_l          = 1'b0;
    advance       = 1'b0;
    done_evt      = 1'b0;
    err_evt       = 1'b0;
    mem_req       = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = ptr_q;
    mem_wdata     = buf_q;
    dev_in_ready  = 1'b0;
    dev_out_valid = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          ptr_n   = base;
          state_n = ST_FADDR;
        end
      end
      ST_FADDR: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (mem_err) begin
            err_evt = 1'b1;
            state_n = ST_IDLE;
          end else begin
            ld_a    = 1'b1;
            last_n  = mem_rdata[0];
            state_n = ST_FLEN;
          end
        end
      end
      ST_FLEN: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + WORD_OFS;
        if (mem_ack) begin
          if (mem_err) begin
            err_evt = 1'b1;
            state_n = ST_IDLE;
          end else begin
            ld_l  = 1'b1;
            ptr_n = ptr_q + ENTRY_OFS;
            if (mem_rdata[LEN_W-1:0] == '0) begin
              done_evt = last_q;
              state_n  = last_q ? ST_IDLE : ST_FADDR;
            end else begin
              state_n = ST_GET;
            end
          end
        end
      end
      ST_GET: begin
        if (dir) begin
          dev_in_ready = 1'b1;
          if (dev_in_valid) begin
            buf_n   = dev_in_data;
            state_n = ST_PUT;
          end
        end else begin
          mem_req  = 1'b1;
          mem_addr = seg_addr;
          if (mem_ack) begin
            if (mem_err) begin
              err_evt = 1'b1;
              state_n = ST_IDLE;
            end else begin
              buf_n   = mem_rdata;
              state_n = ST_PUT;
            end
          end
        end
      end
      ST_PUT: begin
        if (dir) begin
          mem_req  = 1'b1;
          mem_we   = 1'b1;
          mem_addr = seg_addr;
          if (mem_ack) begin
            if (mem_err) begin
              err_evt = 1'b1;
              state_n = ST_IDLE;
            end else begin
              advance = 1'b1;
            end
          end
        end else begin
          dev_out_valid = 1'b1;
          advance       = dev_out_ready;
        end
        if (advance) begin
          if (last_beat) begin
            done_evt = last_q;
            state_n  = last_q ? ST_IDLE : ST_FADDR;
          end else begin
            state_n = ST_GET;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
    step = advance;
    if (hold || stop_req) begin
      state_n  = ST_IDLE;
      done_evt = 1'b0;
      err_evt  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      last_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      last_q  <= last_n;
      buf_q   <= buf_n;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign dev_out_data = buf_q;

  // R13: a request holds with a steady address until acknowledged
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !stop_req && !hold) |=> (mem_req && $stable(mem_addr)));

  // R5: memory is only written in the device-to-memory direction
  assert_write_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> dir);

  // R3: data beats never use the end-mark bit as an address bit
  assert_beat_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (state_q == ST_GET || state_q == ST_PUT)) |-> !mem_addr[0]);

  // R7: a stop leaves the engine idle with no request outstanding
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!busy && !mem_req));

  // R10: hold forces the engine idle
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !busy);

  // R11: completion and error never coincide
  assert_done_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && err_evt));
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready,
  input  logic          dev_irq,
  output logic          done_irq
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          go, stop_req, dir, hold, busy, done_evt, err_evt;
  logic [DW-1:0] base_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sgdma_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .done_evt   (done_evt),
    .err_evt    (err_evt),
    .dev_irq    (dev_irq),
    .go         (go),
    .stop_req   (stop_req),
    .dir        (dir),
    .hold       (hold),
    .base       (base_full),
    .done_pulse (done_irq)
  );

  sgdma_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .go            (go),
    .stop_req      (stop_req),
    .hold          (hold),
    .dir           (dir),
    .base          (base_full[AW-1:0]),
    .busy          (busy),
    .done_evt      (done_evt),
    .err_evt       (err_evt),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_err       (mem_err),
    .mem_rdata     (mem_rdata),
    .dev_in_valid  (dev_in_valid),
    .dev_in_data   (dev_in_data),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .dev_out_data  (dev_out_data),
    .dev_out_ready (dev_out_ready)
  );

  // R8: the completion pulse lasts one cycle and the engine is then idle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_irq |-> (!busy && !$past(done_irq)));
endmodule

// File: tb/sgdma_engine_tb.sv
module sgdma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
  logic [31:0] dev_in_data, dev_out_data;
  logic        dev_irq, done_irq;

  int total = 0;
  int bad = 0;
  int req_cnt = 0;
  int pulse_cnt = 0;
  logic [31:0] dev_seq = 32'd0;
  logic [31:0] mem [int unsigned];
  logic [31:0] dev_log [$];
  logic        err_on = 1'b0;
  logic [31:0] err_addr = 32'h0;
  logic        finished = 1'b0;

  logic [31:0] sa [8];
  logic [28:0] sl [8];
  logic [2:0]  sg [8];

  localparam logic [31:0] TBASE = 32'h0000_0100;

  always #5 clk = ~clk;

  sgdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .dev_irq(dev_irq), .done_irq(done_irq)
  );

  assign dev_in_data = dev_seq;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic int beats(logic [28:0] len);
    return int'((32'(len) + 32'd3) / 32'd4);
  endfunction

  // memory and device models
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      mem_rdata <= 32'h0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (mem_req) begin
      mem_ack   <= 1'b1;
      mem_err   <= err_on && (mem_addr == err_addr);
      mem_rdata <= rd(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
      req_cnt++;
    end
    if (dev_in_valid && dev_in_ready) dev_seq <= dev_seq + 32'd1;
    if (dev_out_valid && dev_out_ready) dev_log.push_back(dev_out_data);
    if (done_irq) pulse_cnt++;
  end

  initial begin
    dev_in_valid = 1'b0;
    dev_out_ready = 1'b0;
    forever begin
      @(negedge clk);
      dev_in_valid  = ($urandom % 4) != 0;
      dev_out_ready = ($urandom % 4) != 0;
    end
  end

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int n = 0;
    rdreg(2'd1, st);
    while (st[0] && n < 20000) begin
      @(negedge clk);
      rdreg(2'd1, st);
      n++;
    end
  endtask

  // build table, run, and compare result
  task automatic run_job(input logic dir, input int nd);
    logic [31:0] exp_q [$];
    logic [31:0] st, ctl;
    int r0, p0, nbeats;
    logic [31:0] seq0;
    exp_q = {};
    dev_log = {};
    nbeats = 0;
    for (int i = 0; i < nd; i++) begin
      mem[TBASE + 32'(8*i)]     = sa[i] | ((i == nd-1) ? 32'h1 : 32'h0);
      mem[TBASE + 32'(8*i) + 4] = {sg[i], sl[i]};
      for (int k = 0; k < beats(sl[i]); k++) begin
        if (!dir) begin
          mem[sa[i] + 32'(4*k)] = $urandom;
          exp_q.push_back(mem[sa[i] + 32'(4*k)]);
        end else begin
          mem[sa[i] + 32'(4*k)] = 32'hDEAD_BEEF;
        end
      end
      nbeats += beats(sl[i]);
    end
    // word just past each segment must stay untouched
    for (int i = 0; i < nd; i++) mem[sa[i] + 32'(4*beats(sl[i]))] = 32'h5A5A_5A5A;
    r0 = req_cnt; p0 = pulse_cnt; seq0 = dev_seq;
    wr(2'd2, TBASE);
    wr(2'd0, {29'd0, dir, 2'b01});
    rdreg(2'd1, st);
    check(st[0] == 1'b1, "R6 active after start", st, 32'h1);
    rdreg(2'd0, ctl);
    check(ctl[0] == 1'b1 && ctl[2] == dir, "R6 R5 control readback", ctl, {29'd0, dir, 2'b01});
    wait_idle();
    @(negedge clk);
    rdreg(2'd1, st);
    check(st == 32'h40, "R8 done flag only", st, 32'h40);
    check(pulse_cnt == p0 + 1, "R8 one completion pulse", 32'(pulse_cnt - p0), 32'd1);
    check(req_cnt - r0 == (dir ? 2*nd + nbeats : 2*nd + nbeats),
          "R2 R9 R13 request count", 32'(req_cnt - r0), 32'(2*nd + nbeats));
    if (!dir) begin
      check(dev_log.size() == exp_q.size(), "R5 R13 device word count",
            32'(dev_log.size()), 32'(exp_q.size()));
      for (int j = 0; j < exp_q.size() && j < dev_log.size(); j++)
        if (dev_log[j] != exp_q[j]) check(1'b0, "R2 R3 R4 device data", dev_log[j], exp_q[j]);
    end else begin
      int idx = 0;
      for (int i = 0; i < nd; i++)
        for (int k = 0; k < beats(sl[i]); k++) begin
          if (rd(sa[i] + 32'(4*k)) != seq0 + 32'(idx))
            check(1'b0, "R2 R3 R5 memory data", rd(sa[i] + 32'(4*k)), seq0 + 32'(idx));
          idx++;
        end
      check(dev_seq - seq0 == 32'(nbeats), "R13 device words taken", dev_seq - seq0, 32'(nbeats));
    end
    for (int i = 0; i < nd; i++)
      if (rd(sa[i] + 32'(4*beats(sl[i]))) != 32'h5A5A_5A5A)
        check(1'b0, "R4 R13 overrun", rd(sa[i] + 32'(4*beats(sl[i]))), 32'h5A5A_5A5A);
    wr(2'd1, 32'h40);
    rdreg(2'd1, st);
    check(st[6] == 1'b0, "R8 done W1C", st, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    int p0, r0;
    v = $urandom(32'd20240611);
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 32'h0; dev_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      rdreg(2'(s), v);
      check(v == 32'h0, "R1 register reset value", v, 32'h0);
    end
    check(!mem_req && !done_irq, "R1 no request or pulse", {30'd0, mem_req, done_irq}, 32'h0);

    // directed: zero length in the middle, garbage upper length bits, mem to device
    sa[0] = 32'h1000_0000; sl[0] = 29'd10; sg[0] = 3'b111;
    sa[1] = 32'h1000_1000; sl[1] = 29'd0;  sg[1] = 3'b101;
    sa[2] = 32'h1000_2000; sl[2] = 29'd4;  sg[2] = 3'b010;
    run_job(1'b0, 3);
    // directed: last entry has zero length, device to memory
    sa[0] = 32'h1000_3000; sl[0] = 29'd7; sg[0] = 3'b100;
    sa[1] = 32'h1000_4000; sl[1] = 29'd0; sg[1] = 3'b011;
    run_job(1'b1, 2);
    // directed: single zero-length entry
    sa[0] = 32'h1000_5000; sl[0] = 29'd0; sg[0] = 3'b000;
    run_job(1'b0, 1);

    // random tables
    for (int t = 0; t < 12; t++) begin
      int nd = 1 + int'($urandom % 5);
      for (int i = 0; i < nd; i++) begin
        sa[i] = 32'h2000_0000 + 32'(t) * 32'h10000 + 32'(i) * 32'h400;
        sl[i] = (($urandom % 6) == 0) ? 29'd0 : 29'(1 + $urandom % 48);
        sg[i] = 3'($urandom);
      end
      run_job(1'($urandom), nd);
    end

    // R7 stop in the middle of a long run
    sa[0] = 32'h3000_0000; sl[0] = 29'd4000; sg[0] = 3'b000;
    mem[TBASE] = sa[0] | 32'h1; mem[TBASE + 4] = {sg[0], sl[0]};
    p0 = pulse_cnt;
    wr(2'd2, TBASE);
    wr(2'd0, 32'h5);
    repeat (30) @(negedge clk);
    wr(2'd0, 32'h6);
    @(negedge clk);
    r0 = req_cnt;
    repeat (10) begin
      @(negedge clk);
      if (mem_req) check(1'b0, "R7 request after stop", 32'h1, 32'h0);
    end
    check(req_cnt == r0, "R7 no request after stop", 32'(req_cnt - r0), 32'h0);
    rdreg(2'd1, v);
    check(v == 32'h0, "R7 idle without done", v, 32'h0);
    check(pulse_cnt == p0, "R7 no completion pulse", 32'(pulse_cnt - p0), 32'h0);

    // R12 device interrupt sticky and W1C
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    @(negedge clk);
    rdreg(2'd1, v);
    check(v[4] == 1'b1, "R12 device interrupt flag set", v, 32'h10);
    wr(2'd1, 32'h10);
    rdreg(2'd1, v);
    check(v[4] == 1'b0, "R12 device interrupt W1C", v, 32'h0);

    // R10 hold: start ignored, run ended, flags cleared
    sa[0] = 32'h3100_0000; sl[0] = 29'd8; sg[0] = 3'b000;
    run_job(1'b1, 1);
    mem[TBASE] = 32'h3200_0001; mem[TBASE + 4] = 32'd4000;
    wr(2'd0, 32'h1);
    repeat (8) @(negedge clk);
    dev_irq = 1'b1;
    wr(2'd0, 32'h81);
    r0 = req_cnt;
    repeat (6) @(negedge clk);
    rdreg(2'd1, v);
    check(v == 32'h0, "R10 hold clears status", v, 32'h0);
    check(req_cnt - r0 <= 1, "R10 no requests under hold", 32'(req_cnt - r0), 32'h0);
    rdreg(2'd0, v);
    check(v == 32'h80, "R10 control shows hold only", v, 32'h80);
    dev_irq = 1'b0;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h54);

    // R11 error response on a data beat
    sa[0] = 32'h3300_0000; sl[0] = 29'd16; sg[0] = 3'b000;
    mem[TBASE] = sa[0] | 32'h1; mem[TBASE + 4] = 32'd16;
    err_on = 1'b1; err_addr = sa[0] + 32'h4;
    p0 = pulse_cnt;
    wr(2'd2, TBASE);
    wr(2'd0, 32'h1);
    wait_idle();
    @(negedge clk);
    rdreg(2'd1, v);
    check(v == 32'h4, "R11 error flag without done", v, 32'h4);
    check(pulse_cnt == p0, "R11 no completion pulse", 32'(pulse_cnt - p0), 32'h0);
    err_on = 1'b0;
    wr(2'd1, 32'h4);
    rdreg(2'd1, v);
    check(v == 32'h0, "R11 error W1C", v, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R6 actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule